// File: doc/BRIEF.md
# VM Operand Address Generator

This block prepares the memory addresses and the second source operand for one decoded instruction of a randomized 64-bit virtual machine that has eight integer registers. When an instruction is strobed in, the block reads up to three registers through external read ports. It then produces three things:

- For the first operand, it flips the selected register with a sign-extended 32-bit mask. It hands the modified value back for writeback and turns it into an 8-byte aligned read address.
- For the destination operand, it combines a register with the instruction's 32-bit immediate to form a write address. That register is left unchanged.
- For the second operand, it picks either a register or an immediate.

Each location code picks which region an address falls in. A code can select the whole scratchpad, a small first-level window at its start, or no memory access at all. All results appear, registered, one cycle after the input strobe. The block keeps its own pending writeback and forwards it, so instructions may be issued on consecutive cycles. The memory and all arithmetic stay outside the block.

Top module: `vm_operand_agen`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. Synchronous reset drives `out_valid`, `wb_en` and every other output to zero.
- R2: For each strobed instruction, the next cycle shows `wb_en`=1, `wb_idx`=`a_reg`, and `wb_data` = (current value of register `a_reg`) XOR (`a_mask` sign-extended to 64 bits).
- R3: Read region encoding: `rd_sel` is 2 (full) when `a_loc`=0, 1 (small) when `a_loc` is 1 to 3, and 0 (none) when `a_loc` is 4 to 7. In the full region, `rd_addr` = 8*(updated A value AND (FULL_WORDS-1)). In the small region it is 8*(updated A value AND (SMALL_WORDS-1)). With no region it is 0.
- R4: `c_loc` is decoded the same way onto `wr_sel`. `wr_addr` = 8*((`imm32` XOR low 32 bits of register `c_reg`) AND region mask), or 0 for no region. The C register is never written back.
- R5: When `c_reg` equals `a_reg`, the write address uses the register value from before the A update.
- R6: When `b_loc` is 0 to 5, `b_val` is register `b_reg`. If `b_reg` equals `a_reg`, it is the value after the A update.
- R7: When `b_loc` is 6 or 7, `b_val` is `imm8` zero-extended if `b_shift`=1. Otherwise it is `imm32` sign-extended to 64 bits.
- R8: An instruction strobed in the cycle right after another sees that earlier instruction's writeback value on any read port whose index matches `wb_idx`.
- R9: In a cycle after `in_valid` was low, `rd_sel`, `rd_addr`, `wr_sel`, `wr_addr`, `b_val`, `wb_idx` and `wb_data` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| a_reg | input | 3 | Register index for operand A |
| a_loc | input | 3 | Location code for operand A |
| b_reg | input | 3 | Register index for operand B |
| b_loc | input | 3 | Location code for operand B |
| c_reg | input | 3 | Register index for operand C |
| c_loc | input | 3 | Location code for operand C |
| b_shift | input | 1 | Instruction is a shift or rotate (selects the 8-bit immediate) |
| imm8 | input | 8 | 8-bit immediate |
| a_mask | input | 32 | Address mask for operand A |
| imm32 | input | 32 | 32-bit immediate, also the C address mask |
| rf_a_idx | output | 3 | Register file read index, port A |
| rf_a_data | input | 64 | Register file read data, port A |
| rf_b_idx | output | 3 | Register file read index, port B |
| rf_b_data | input | 64 | Register file read data, port B |
| rf_c_idx | output | 3 | Register file read index, port C |
| rf_c_data | input | 64 | Register file read data, port C |
| out_valid | output | 1 | Results valid |
| rd_sel | output | 2 | Read region: 0 none, 1 small, 2 full |
| rd_addr | output | AW | Byte read address |
| wr_sel | output | 2 | Write region: 0 none, 1 small, 2 full |
| wr_addr | output | AW | Byte write address |
| b_val | output | 64 | Operand B value |
| wb_en | output | 1 | Register writeback enable |
| wb_idx | output | 3 | Register writeback index |
| wb_data | output | 64 | Register writeback data |

## Verification
The in-design assertions watch the following on every cycle:
- the one-cycle valid timing;
- the link between the writeback index and the strobed A register;
- address alignment, the bound on the small region, and a zero address when no region is selected;
- the sign-extended 32-bit immediate on B;
- output stability across idle cycles.

Other properties need the bench's reference model and its directed scenarios:
- the actual mask-and-XOR address values;
- the ordering rules when A, B and C name the same register, where C sees the old value and B the new one;
- forwarding between back-to-back instructions.

// File: rtl/vmag_pkg.sv
package vmag_pkg;

    localparam int XLEN  = 64;
    localparam int IDX_W = 3;
    localparam int LOC_W = 3;

    typedef logic [XLEN-1:0]  word_t;
    typedef logic [IDX_W-1:0] ridx_t;
    typedef logic [LOC_W-1:0] loc_t;

    // Region a location code maps onto
    typedef enum logic [1:0] {
        REGION_NONE  = 2'd0,
        REGION_SMALL = 2'd1,
        REGION_FULL  = 2'd2
    } region_e;

    // B location codes at or above this value pick an immediate
    localparam loc_t B_IMM_FIRST = 3'd6;

    // Pending register writeback, also used as the forwarding source
    typedef struct packed {
        logic  en;
        ridx_t idx;
        word_t data;
    } wback_t;

    function automatic region_e region_of(loc_t loc);
        region_e r;
        if (loc == 3'd0)       r = REGION_FULL;
        else if (loc <= 3'd3)  r = REGION_SMALL;
        else                   r = REGION_NONE;
        return r;
    endfunction

    function automatic word_t sext32(logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

endpackage

// File: rtl/vmag_fwd.sv
module vmag_fwd
    import vmag_pkg::*;
(
    input  ridx_t  idx,
    input  word_t  rf_data,
    input  wback_t wb,
    output word_t  data
);
    // Pending writeback wins over the not-yet-updated register file
    always_comb begin
        if (wb.en && (wb.idx == idx)) data = wb.data;
        else                          data = rf_data;
    end
endmodule

// File: rtl/vmag_addr.sv
module vmag_addr
    import vmag_pkg::*;
#(
    parameter  int FULL_WORDS  = 32768,
    parameter  int SMALL_WORDS = 2048,
    localparam int AW          = $clog2(FULL_WORDS) + 3
) (
    input  loc_t            loc,
    input  word_t           key,
    output region_e         region,
    output logic [AW-1:0]   byte_addr
);
    localparam word_t FULL_MASK  = word_t'(FULL_WORDS - 1);
    localparam word_t SMALL_MASK = word_t'(SMALL_WORDS - 1);

    word_t mask;
    word_t word_idx;

    always_comb begin
        region = region_of(loc);
        case (region)
            REGION_FULL:  mask = FULL_MASK;
            REGION_SMALL: mask = SMALL_MASK;
            default:      mask = '0;
        endcase
        word_idx  = key & mask;
        byte_addr = AW'(word_idx << 3);
    end
endmodule

// File: rtl/vmag_bsel.sv
module vmag_bsel
    import vmag_pkg::*;
(
    input  loc_t        b_loc,
    input  logic        b_shift,
    input  word_t       reg_val,
    input  logic [7:0]  imm8,
    input  logic [31:0] imm32,
    output word_t       b_val
);
    always_comb begin
        if (b_loc >= B_IMM_FIRST) begin
            if (b_shift) b_val = {{(XLEN-8){1'b0}}, imm8};
            else         b_val = sext32(imm32);
        end else begin
            b_val = reg_val;
        end
    end
endmodule

// File: rtl/vm_operand_agen.sv
module vm_operand_agen
    import vmag_pkg::*;
#(
    parameter  int FULL_WORDS  = 32768,
    parameter  int SMALL_WORDS = 2048,
    localparam int AW          = $clog2(FULL_WORDS) + 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    a_reg,
    input  logic [2:0]    a_loc,
    input  logic [2:0]    b_reg,
    input  logic [2:0]    b_loc,
    input  logic [2:0]    c_reg,
    input  logic [2:0]    c_loc,
    input  logic          b_shift,
    input  logic [7:0]    imm8,
    input  logic [31:0]   a_mask,
    input  logic [31:0]   imm32,
    output logic [2:0]    rf_a_idx,
    input  logic [63:0]   rf_a_data,
    output logic [2:0]    rf_b_idx,
    input  logic [63:0]   rf_b_data,
    output logic [2:0]    rf_c_idx,
    input  logic [63:0]   rf_c_data,
    output logic          out_valid,
    output logic [1:0]    rd_sel,
    output logic [AW-1:0] rd_addr,
    output logic [1:0]    wr_sel,
    output logic [AW-1:0] wr_addr,
    output logic [63:0]   b_val,
    output logic          wb_en,
    output logic [2:0]    wb_idx,
    output logic [63:0]   wb_data
);
    localparam int NPORT = 3;
    localparam int P_A = 0;
    localparam int P_B = 1;
    localparam int P_C = 2;

    // Registered state
    logic          valid_q;
    region_e       rd_sel_q, wr_sel_q;
    logic [AW-1:0] rd_addr_q, wr_addr_q;
    word_t         b_val_q;
    wback_t        wb_q;

    // Read ports with forwarding from the pending writeback
    ridx_t port_idx  [NPORT];
    word_t port_data [NPORT];
    word_t fwd_data  [NPORT];

    assign port_idx[P_A]  = a_reg;
    assign port_idx[P_B]  = b_reg;
    assign port_idx[P_C]  = c_reg;
    assign port_data[P_A] = rf_a_data;
    assign port_data[P_B] = rf_b_data;
    assign port_data[P_C] = rf_c_data;

    assign rf_a_idx = port_idx[P_A];
    assign rf_b_idx = port_idx[P_B];
    assign rf_c_idx = port_idx[P_C];

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        vmag_fwd u_fwd (
            .idx     (port_idx[p]),
            .rf_data (port_data[p]),
            .wb      (wb_q),
            .data    (fwd_data[p])
        );
    end

    // Operand A: register flipped by the sign-extended mask
    word_t a_new;
    assign a_new = fwd_data[P_A] ^ sext32(a_mask);

    // Operand B sees the A update; operand C does not
    word_t b_reg_val;
    assign b_reg_val = (b_reg == a_reg) ? a_new : fwd_data[P_B];

    word_t c_key;
    assign c_key = {32'h0, imm32} ^ fwd_data[P_C];

    region_e       rd_sel_d, wr_sel_d;
    logic [AW-1:0] rd_addr_d, wr_addr_d;
    word_t         b_val_d;

    vmag_addr #(.FULL_WORDS(FULL_WORDS), .SMALL_WORDS(SMALL_WORDS)) u_rd_addr (
        .loc       (a_loc),
        .key       (a_new),
        .region    (rd_sel_d),
        .byte_addr (rd_addr_d)
    );

    vmag_addr #(.FULL_WORDS(FULL_WORDS), .SMALL_WORDS(SMALL_WORDS)) u_wr_addr (
        .loc       (c_loc),
        .key       (c_key),
        .region    (wr_sel_d),
        .byte_addr (wr_addr_d)
    );

    vmag_bsel u_bsel (
        .b_loc   (b_loc),
        .b_shift (b_shift),
        .reg_val (b_reg_val),
        .imm8    (imm8),
        .imm32   (imm32),
        .b_val   (b_val_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            rd_sel_q  <= REGION_NONE;
            wr_sel_q  <= REGION_NONE;
            rd_addr_q <= '0;
            wr_addr_q <= '0;
            b_val_q   <= '0;
            wb_q      <= '0;
        end else begin
            valid_q <= in_valid;
            wb_q.en <= in_valid;
            if (in_valid) begin
                rd_sel_q   <= rd_sel_d;
                wr_sel_q   <= wr_sel_d;
                rd_addr_q  <= rd_addr_d;
                wr_addr_q  <= wr_addr_d;
                b_val_q    <= b_val_d;
                wb_q.idx   <= a_reg;
                wb_q.data  <= a_new;
            end
        end
    end

    assign out_valid = valid_q;
    assign rd_sel    = rd_sel_q;
    assign wr_sel    = wr_sel_q;
    assign rd_addr   = rd_addr_q;
    assign wr_addr   = wr_addr_q;
    assign b_val     = b_val_q;
    assign wb_en     = wb_q.en;
    assign wb_idx    = wb_q.idx;
    assign wb_data   = wb_q.data;

    // Assertions
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (out_valid == $past(in_valid)));   // R1

    AST_WB_INDEX_IS_A: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_valid) |-> (wb_en && wb_idx == $past(a_reg)));   // R2

    AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        rd_addr[2:0] == 3'b000);   // R3

    AST_RD_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == 2'd0) |-> (rd_addr == '0));   // R3

    AST_WR_SMALL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (wr_sel == 2'd1) |-> (int'(wr_addr) < SMALL_WORDS * 8));   // R4

    AST_B_IMM_SEXT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && b_loc >= B_IMM_FIRST && !b_shift) |=> (b_val == sext32($past(imm32))));   // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(rd_addr) && $stable(wr_addr) && $stable(b_val) && $stable(wb_data)));   // R9

endmodule

// File: tb/vm_operand_agen_test.sv
`timescale 1ns/1ps
module vm_operand_agen_test;

    localparam int FULL_WORDS  = 32768;
    localparam int SMALL_WORDS = 2048;
    localparam int AW          = $clog2(FULL_WORDS) + 3;
    localparam int MAX_CYCLES  = 20000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst;
    logic          in_valid;
    logic [2:0]    a_reg, a_loc, b_reg, b_loc, c_reg, c_loc;
    logic          b_shift;
    logic [7:0]    imm8;
    logic [31:0]   a_mask, imm32;
    logic [2:0]    rf_a_idx, rf_b_idx, rf_c_idx;
    logic [63:0]   rf_a_data, rf_b_data, rf_c_data;
    logic          out_valid;
    logic [1:0]    rd_sel, wr_sel;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [63:0]   b_val;
    logic          wb_en;
    logic [2:0]    wb_idx;
    logic [63:0]   wb_data;

    vm_operand_agen #(.FULL_WORDS(FULL_WORDS), .SMALL_WORDS(SMALL_WORDS)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_reg(a_reg), .a_loc(a_loc), .b_reg(b_reg), .b_loc(b_loc),
        .c_reg(c_reg), .c_loc(c_loc), .b_shift(b_shift), .imm8(imm8),
        .a_mask(a_mask), .imm32(imm32),
        .rf_a_idx(rf_a_idx), .rf_a_data(rf_a_data),
        .rf_b_idx(rf_b_idx), .rf_b_data(rf_b_data),
        .rf_c_idx(rf_c_idx), .rf_c_data(rf_c_data),
        .out_valid(out_valid), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .b_val(b_val),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    // Bench register file, written from the block's writeback port
    logic [63:0] rf [8];
    assign rf_a_data = rf[rf_a_idx];
    assign rf_b_data = rf[rf_b_idx];
    assign rf_c_data = rf[rf_c_idx];
    always @(posedge clk) if (wb_en) rf[wb_idx] <= wb_data;

    // Reference model state
    logic [63:0] mdl [8];
    logic        e_valid;
    logic [1:0]  e_rsel, e_wsel;
    logic [63:0] e_raddr, e_waddr, e_b, e_wbdata;
    logic [2:0]  e_wbidx;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 0;

    task automatic chk(string req, string scen, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (%s): actual=%h expected=%h", req, scen, act, exp);
        end
    endtask

    function automatic logic [1:0] region(logic [2:0] loc);
        if (loc == 0) return 2'd2;
        if (loc <= 3) return 2'd1;
        return 2'd0;
    endfunction

    function automatic logic [63:0] mkaddr(logic [2:0] loc, logic [63:0] key);
        logic [63:0] w;
        case (region(loc))
            2'd2:    w = key % FULL_WORDS;
            2'd1:    w = key % SMALL_WORDS;
            default: w = 0;
        endcase
        return (w * 8) % (64'd1 << AW);
    endfunction

    // One cycle: drive, update model, clock, compare
    task automatic step(bit v, logic [2:0] ar, logic [2:0] al, logic [2:0] br, logic [2:0] bl,
                        logic [2:0] cr, logic [2:0] cl, bit sh, logic [7:0] i8,
                        logic [31:0] m, logic [31:0] i32, string scen);
        logic [63:0] av;
        in_valid = v; a_reg = ar; a_loc = al; b_reg = br; b_loc = bl;
        c_reg = cr; c_loc = cl; b_shift = sh; imm8 = i8; a_mask = m; imm32 = i32;
        e_valid = v;
        if (v) begin
            av      = mdl[ar] ^ {{32{m[31]}}, m};
            e_rsel  = region(al);
            e_raddr = mkaddr(al, av);
            e_wsel  = region(cl);
            e_waddr = mkaddr(cl, {32'h0, i32} ^ mdl[cr]);
            if (bl < 6)  e_b = (br == ar) ? av : mdl[br];
            else if (sh) e_b = {56'h0, i8};
            else         e_b = {{32{i32[31]}}, i32};
            e_wbidx  = ar;
            e_wbdata = av;
            mdl[ar]  = av;
        end
        @(posedge clk);
        #2;
        chk("R1", scen, {63'h0, out_valid}, {63'h0, e_valid});
        chk("R2", scen, {63'h0, wb_en}, {63'h0, e_valid});
        if (v) begin
            chk("R2", scen, {61'h0, wb_idx}, {61'h0, e_wbidx});
            chk("R2", scen, wb_data, e_wbdata);
            chk("R3", scen, {62'h0, rd_sel}, {62'h0, e_rsel});
            chk("R3", scen, 64'(rd_addr), e_raddr);
            chk("R4", scen, {62'h0, wr_sel}, {62'h0, e_wsel});
            chk("R4", scen, 64'(wr_addr), e_waddr);
            chk((bl < 6) ? "R6" : "R7", scen, b_val, e_b);
        end else begin
            // R9: everything keeps the last instruction's values
            chk("R9", scen, {62'h0, rd_sel}, {62'h0, e_rsel});
            chk("R9", scen, 64'(rd_addr), e_raddr);
            chk("R9", scen, 64'(wr_addr), e_waddr);
            chk("R9", scen, b_val, e_b);
            chk("R9", scen, wb_data, e_wbdata);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(MAX_CYCLES * 10);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        in_valid = 0; a_reg = 0; a_loc = 0; b_reg = 0; b_loc = 0;
        c_reg = 0; c_loc = 0; b_shift = 0; imm8 = 0; a_mask = 0; imm32 = 0;
        for (int i = 0; i < 8; i++) begin
            rf[i]  = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 3) + 64'(i);
            mdl[i] = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 3) + 64'(i);
        end
        e_valid = 0; e_rsel = 0; e_wsel = 0; e_raddr = 0; e_waddr = 0;
        e_b = 0; e_wbidx = 0; e_wbdata = 0;
        repeat (3) @(posedge clk);
        #2;
        rst = 1'b0;
        // R1: reset state
        chk("R1", "reset", {63'h0, out_valid}, 64'h0);
        chk("R1", "reset", {63'h0, wb_en}, 64'h0);
        chk("R1", "reset", 64'(rd_addr), 64'h0);
        chk("R1", "reset", b_val, 64'h0);

        // Negative A mask, full regions, sign-extended imm32 on B (R2 R3 R4 R7)
        step(1, 3'd1, 3'd0, 3'd5, 3'd6, 3'd2, 3'd0, 0, 8'h3C, 32'h8000_0001, 32'hFFFF_F000, "full regions");
        // Back-to-back on the same A register, B names it too (R8 R6)
        step(1, 3'd1, 3'd2, 3'd1, 3'd3, 3'd4, 3'd1, 0, 8'h00, 32'h0000_7FF8, 32'h1234_5678, "R8 back-to-back A, B==A");
        // C names the previous A register: forwarded; and C==A in same instr (R8 R5)
        step(1, 3'd6, 3'd3, 3'd2, 3'd0, 3'd1, 3'd0, 0, 8'h00, 32'h0F0F_0F0F, 32'h0000_ABCD, "R8 forward to C");
        step(1, 3'd3, 3'd0, 3'd6, 3'd5, 3'd3, 3'd2, 0, 8'h00, 32'hFFFF_FFFF, 32'h7654_3210, "R5 C==A pre-update");
        // Shift immediate, zero-extended imm8 (R7)
        step(1, 3'd0, 3'd1, 3'd7, 3'd7, 3'd5, 3'd3, 1, 8'hFF, 32'h0000_0040, 32'h8000_0000, "R7 imm8 shift");
        // No-memory codes for A and C (R3 R4)
        step(1, 3'd7, 3'd4, 3'd0, 3'd4, 3'd7, 3'd7, 0, 8'h11, 32'hDEAD_BEEF, 32'hCAFE_F00D, "no region");
        step(1, 3'd2, 3'd7, 3'd2, 3'd2, 3'd6, 3'd5, 1, 8'h22, 32'h1357_9BDF, 32'h2468_ACE0, "R6 B==A post-update");
        // Idle gap (R9)
        step(0, 3'd5, 3'd0, 3'd1, 3'd0, 3'd2, 3'd0, 0, 8'h99, 32'hFFFF_0000, 32'h0000_FFFF, "idle");
        step(0, 3'd4, 3'd1, 3'd3, 3'd6, 3'd4, 3'd1, 1, 8'h77, 32'h1111_1111, 32'h2222_2222, "idle");
        // After a gap, the register file itself holds the update (R2)
        step(1, 3'd2, 3'd0, 3'd3, 3'd1, 3'd2, 3'd0, 0, 8'h00, 32'h0000_0000, 32'h0000_0000, "read after gap");

        // Mixed stream
        for (int n = 0; n < 400; n++) begin
            bit v;
            v = ($urandom % 4) != 0;
            step(v, 3'($urandom), 3'($urandom), 3'($urandom), 3'($urandom),
                 3'($urandom), 3'($urandom), 1'($urandom), 8'($urandom),
                 $urandom, $urandom, "mixed");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "drain");
        finish_run();
    end

endmodule